// File: doc/BRIEF.md
# Spiking Neuron Timestep Update Unit

This block advances a population of integer spiking neurons by one simulated timestep. Charge is not held in a per-neuron register. It lives in a small circular buffer whose rows are time slots and whose columns are neurons. A synapse stage deposits weighted charge into a future row by giving a delay relative to the current row. When `start_i` is pulsed, the unit walks the neurons in fixed-width lane groups, one group per clock. For each neuron it reads the charge in the current row and raises it to the global minimum potential if it is lower. It then compares the result with that neuron's own threshold. A neuron that neither fired nor leaks has its charge added into the same column of the following row.

Once the last group has been processed, the unit wipes the current row, advances the ring pointer and pulses `done_o`. At that point the packed fired mask is complete, and it stays stable until the next start. The downstream propagation stage reads the mask and deposits new charge for later timesteps. Thresholds, leak flags, the leak mode and the minimum potential are presented as flat inputs from configuration tables. All arithmetic is signed two's complement, and every addition into the buffer saturates.

Top module: `nrn_step_unit`

## Requirements
- R1: After `rst_ni` is asserted low, `fired_o` is all zero, `done_o` and `busy_o` are low, and every buffer entry is zero.
- R2: Before the threshold test and before any carry, a neuron's charge is replaced by `min_pot_i` when the charge is lower (signed comparison).
- R3: Neuron n fires when its clamped charge is greater than or equal to its threshold `thr_i[n*CW +: CW]` (signed). Each neuron has its own threshold.
- R4: A neuron with threshold 0 fires on every step with no input while `min_pot_i` is at least 0. It does not fire when its clamped charge is negative.
- R5: A neuron that did not fire and does not leak has its clamped charge added into the same column of the next row (pointer plus one, modulo `T_STEPS`), where it joins the next step's input.
- R6: `leak_mode_i` encodes leak behaviour as follows: 0 means no neuron leaks, 1 means every neuron leaks (nothing is carried), and 2 means neuron n leaks exactly when `leak_mask_i[n]` is 1.
- R7: The charge of a neuron that fired is never carried into the next row.
- R8: At the end of each step every entry of the current row is set to zero, and the row pointer advances modulo `T_STEPS`. Stale charge never reappears when the ring wraps.
- R9: Neurons are processed `LANES` at a time. The final group handles only the remaining neurons, and those neurons fire and carry like any other.
- R10: Carry additions and deposits saturate at the signed limits of the CW-bit charge word instead of wrapping.
- R11: A start taken while idle raises `busy_o`, and `done_o` pulses for exactly one cycle `N_GROUPS+1` cycles after the start cycle. A start while busy is ignored. `fired_o` holds its value from `done_o` until the next start.
- R12: A deposit presented while `busy_o` is high is discarded.
- R13: A deposit with delay d into column c while idle is added, with saturation, to row (pointer + d) mod `T_STEPS`. It is seen by the (d+1)-th following step, so delay 0 means the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one timestep (taken when idle) |
| leak_mode_i | input | 2 | 0 none, 1 all, 2 per-neuron |
| min_pot_i | input | CW | Signed minimum potential |
| thr_i | input | N_NEURONS*CW | Packed signed thresholds, neuron n at bits n*CW |
| leak_mask_i | input | N_NEURONS | Per-neuron leak flags for mode 2 |
| dep_valid_i | input | 1 | Deposit strobe from the synapse stage |
| dep_col_i | input | $clog2(N_NEURONS) | Destination neuron of the deposit |
| dep_delay_i | input | $clog2(T_STEPS) | Delay in steps relative to the current row |
| dep_val_i | input | CW | Signed charge to add |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle pulse at the end of a step |
| fired_o | output | N_NEURONS | Packed fired mask of the last step |

## Verification
The assertions run on every cycle. They check that `done_o` lasts a single cycle, that the group counter steps by one while processing, and that `fired_o` cannot move while the unit is idle without a start. They also check that a wiped row reads as zero on the following cycle, that no saturating sum wraps in sign, and that with leak mode 0 exactly the unfired lanes carry. Directed bench scenarios cover the behaviours that depend on values: the inclusive threshold edge, clamping, zero thresholds, the three leak modes, delayed deposits, and suppression of carry after a fire. They also cover the partial last group, saturation across two steps, discarded deposits and starts during a step, and the absence of stale charge after a full ring wrap.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
  localparam logic [1:0] LEAK_NONE = 2'd0;
  localparam logic [1:0] LEAK_ALL  = 2'd1;
  localparam logic [1:0] LEAK_CFG  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROC = 2'd1,
    ST_CLR  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nrn_seq.sv
module nrn_seq
  import nrn_pkg::*;
#(
  parameter int N_GROUPS = 3,
  parameter int T_STEPS  = 4,
  parameter int GW       = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
  parameter int RW       = $clog2(T_STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          take_o,
  output logic          proc_o,
  output logic [GW-1:0] grp_o,
  output logic          clr_o,
  output logic          done_o,
  output logic [RW-1:0] row_o,
  output logic [RW-1:0] nrow_o
);
  seq_state_e    state_q;
  logic [GW-1:0] grp_q;
  logic [RW-1:0] row_q;
  logic          last_grp;

  assign last_grp = (grp_q == GW'(N_GROUPS - 1));
  assign nrow_o   = (row_q == RW'(T_STEPS - 1)) ? '0 : row_q + 1'b1;
  assign row_o    = row_q;
  assign grp_o    = grp_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign take_o   = (state_q == ST_IDLE) && start_i;
  assign proc_o   = (state_q == ST_PROC);
  assign clr_o    = (state_q == ST_CLR);
  assign done_o   = clr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      row_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PROC;
          grp_q   <= '0;
        end
        ST_PROC: begin
          if (last_grp) state_q <= ST_CLR;
          else          grp_q   <= grp_q + 1'b1;
        end
        ST_CLR: begin
          row_q   <= nrow_o;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_grp_adv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_o && !last_grp) |=> (proc_o && grp_q == $past(grp_q) + 1'b1));
endmodule

// File: rtl/nrn_lane.sv
module nrn_lane #(
  parameter int CW = 8
) (
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [CW-1:0] charge_i,
  input  logic signed [CW-1:0] thr_i,
  input  logic signed [CW-1:0] min_pot_i,
  input  logic                 leak_i,
  input  logic signed [CW-1:0] next_i,
  output logic                 fired_o,
  output logic                 carry_en_o,
  output logic signed [CW-1:0] carry_val_o
);
  logic signed [CW-1:0] clamped;
  logic signed [CW:0]   sum;

  assign clamped     = (charge_i < min_pot_i) ? min_pot_i : charge_i;
  assign fired_o     = valid_i && (clamped >= thr_i);
  assign carry_en_o  = valid_i && !(fired_o || leak_i);
  assign sum         = {next_i[CW-1], next_i} + {clamped[CW-1], clamped};
  assign carry_val_o = (sum[CW] != sum[CW-1]) ?
                       (sum[CW] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}}) :
                       sum[CW-1:0];

  always_comb begin
    if (rst_ni === 1'b1 && valid_i === 1'b1 && !next_i[CW-1] && !clamped[CW-1])
      p_no_wrap_r10: assert (!carry_val_o[CW-1]);
  end
endmodule

// File: rtl/nrn_charge_mem.sv
module nrn_charge_mem #(
  parameter int N_NEURONS = 20,
  parameter int T_STEPS   = 4,
  parameter int CW        = 8,
  parameter int LANES     = 8,
  parameter int NW        = $clog2(N_NEURONS),
  parameter int RW        = $clog2(T_STEPS),
  parameter int CLW       = $clog2(N_NEURONS + LANES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RW-1:0]        rd_row_i,
  input  logic [RW-1:0]        nx_row_i,
  input  logic [CLW-1:0]       base_i,
  output logic signed [CW-1:0] rd_o [LANES],
  output logic signed [CW-1:0] nx_o [LANES],
  input  logic [LANES-1:0]     wr_en_i,
  input  logic signed [CW-1:0] wr_val_i [LANES],
  input  logic                 dep_en_i,
  input  logic [RW-1:0]        dep_row_i,
  input  logic [NW-1:0]        dep_col_i,
  input  logic signed [CW-1:0] dep_val_i,
  input  logic                 clr_i,
  input  logic [RW-1:0]        clr_row_i
);
  logic signed [CW-1:0] mem_q [T_STEPS][N_NEURONS];
  logic [CLW-1:0]       lane_col [LANES];
  logic [LANES-1:0]     lane_ok;
  logic signed [CW-1:0] dep_old, dep_new;
  logic signed [CW:0]   dep_sum;
  logic                 dep_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_col
    assign lane_col[l] = base_i + CLW'(l);
    assign lane_ok[l]  = lane_col[l] < CLW'(N_NEURONS);
    assign rd_o[l] = lane_ok[l] ? mem_q[rd_row_i][lane_col[l][NW-1:0]] : '0;
    assign nx_o[l] = lane_ok[l] ? mem_q[nx_row_i][lane_col[l][NW-1:0]] : '0;
  end

  assign dep_ok  = {1'b0, dep_col_i} < (NW+1)'(N_NEURONS);
  assign dep_old = dep_ok ? mem_q[dep_row_i][dep_col_i] : '0;
  assign dep_sum = {dep_old[CW-1], dep_old} + {dep_val_i[CW-1], dep_val_i};
  assign dep_new = (dep_sum[CW] != dep_sum[CW-1]) ?
                   (dep_sum[CW] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}}) :
                   dep_sum[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < T_STEPS; t++)
        for (int c = 0; c < N_NEURONS; c++)
          mem_q[t][c] <= '0;
    end else begin
      if (clr_i)
        for (int c = 0; c < N_NEURONS; c++)
          mem_q[clr_row_i][c] <= '0;
      for (int l = 0; l < LANES; l++)
        if (wr_en_i[l] && lane_ok[l])
          mem_q[nx_row_i][lane_col[l][NW-1:0]] <= wr_val_i[l];
      if (dep_en_i && dep_ok)
        mem_q[dep_row_i][dep_col_i] <= dep_new;
    end
  end

  function automatic logic row_zero(input logic [RW-1:0] r);
    logic z;
    z = 1'b1;
    for (int c = 0; c < N_NEURONS; c++)
      if (mem_q[r][c] != '0) z = 1'b0;
    return z;
  endfunction

  p_row_wiped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> row_zero($past(clr_row_i)));

  p_dep_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dep_en_i && dep_ok && !dep_old[CW-1] && !dep_val_i[CW-1]) |=>
      !mem_q[$past(dep_row_i)][$past(dep_col_i)][CW-1]);
endmodule

// File: rtl/nrn_step_unit.sv
module nrn_step_unit
  import nrn_pkg::*;
#(
  parameter int N_NEURONS = 20,
  parameter int LANES     = 8,
  parameter int T_STEPS   = 4,
  parameter int CW        = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    leak_mode_i,
  input  logic signed [CW-1:0]          min_pot_i,
  input  logic [N_NEURONS*CW-1:0]       thr_i,
  input  logic [N_NEURONS-1:0]          leak_mask_i,
  input  logic                          dep_valid_i,
  input  logic [$clog2(N_NEURONS)-1:0]  dep_col_i,
  input  logic [$clog2(T_STEPS)-1:0]    dep_delay_i,
  input  logic signed [CW-1:0]          dep_val_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [N_NEURONS-1:0]          fired_o
);
  localparam int N_GROUPS = (N_NEURONS + LANES - 1) / LANES;
  localparam int NW       = $clog2(N_NEURONS);
  localparam int RW       = $clog2(T_STEPS);
  localparam int GW       = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int CLW      = $clog2(N_NEURONS + LANES);

  logic          take, proc, clr;
  logic [GW-1:0] grp;
  logic [RW-1:0] row, nrow, dep_row;
  logic [RW:0]   dep_sum;
  logic [CLW-1:0] base;
  logic          dep_en;

  logic signed [CW-1:0] thr_arr [N_NEURONS];
  logic [CLW-1:0]       lane_col [LANES];
  logic [LANES-1:0]     lane_ok, lane_fired, lane_carry, lane_leak;
  logic signed [CW-1:0] lane_thr [LANES];
  logic signed [CW-1:0] rd_chg [LANES];
  logic signed [CW-1:0] nx_chg [LANES];
  logic signed [CW-1:0] carry_val [LANES];
  logic [N_NEURONS-1:0] fired_q;

  nrn_seq #(.N_GROUPS(N_GROUPS), .T_STEPS(T_STEPS), .GW(GW), .RW(RW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .take_o  (take),
    .proc_o  (proc),
    .grp_o   (grp),
    .clr_o   (clr),
    .done_o  (done_o),
    .row_o   (row),
    .nrow_o  (nrow)
  );

  assign base = CLW'(32'(grp) * LANES);

  // deposit target row, delay assumed below T_STEPS
  assign dep_sum = {1'b0, row} + {1'b0, dep_delay_i};
  assign dep_row = (dep_sum >= (RW+1)'(T_STEPS)) ? RW'(dep_sum - (RW+1)'(T_STEPS)) : dep_sum[RW-1:0];
  assign dep_en  = dep_valid_i && !busy_o;

  for (genvar n = 0; n < N_NEURONS; n++) begin : g_thr
    assign thr_arr[n] = thr_i[n*CW +: CW];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_col[l] = base + CLW'(l);
    assign lane_ok[l]  = proc && (lane_col[l] < CLW'(N_NEURONS));
    assign lane_thr[l] = lane_ok[l] ? thr_arr[lane_col[l][NW-1:0]] : '0;

    always_comb begin
      case (leak_mode_i)
        LEAK_ALL: lane_leak[l] = 1'b1;
        LEAK_CFG: lane_leak[l] = lane_ok[l] ? leak_mask_i[lane_col[l][NW-1:0]] : 1'b0;
        default:  lane_leak[l] = 1'b0;
      endcase
    end

    nrn_lane #(.CW(CW)) u_lane (
      .rst_ni      (rst_ni),
      .valid_i     (lane_ok[l]),
      .charge_i    (rd_chg[l]),
      .thr_i       (lane_thr[l]),
      .min_pot_i   (min_pot_i),
      .leak_i      (lane_leak[l]),
      .next_i      (nx_chg[l]),
      .fired_o     (lane_fired[l]),
      .carry_en_o  (lane_carry[l]),
      .carry_val_o (carry_val[l])
    );

    p_leak_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_ok[l] && leak_mode_i == LEAK_NONE) |-> (lane_carry[l] == !lane_fired[l]));
  end

  nrn_charge_mem #(
    .N_NEURONS(N_NEURONS), .T_STEPS(T_STEPS), .CW(CW), .LANES(LANES),
    .NW(NW), .RW(RW), .CLW(CLW)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_row_i  (row),
    .nx_row_i  (nrow),
    .base_i    (base),
    .rd_o      (rd_chg),
    .nx_o      (nx_chg),
    .wr_en_i   (lane_carry),
    .wr_val_i  (carry_val),
    .dep_en_i  (dep_en),
    .dep_row_i (dep_row),
    .dep_col_i (dep_col_i),
    .dep_val_i (dep_val_i),
    .clr_i     (clr),
    .clr_row_i (row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= '0;
    end else if (take) begin
      fired_q <= '0;
    end else if (proc) begin
      for (int l = 0; l < LANES; l++)
        if (lane_ok[l]) fired_q[lane_col[l][NW-1:0]] <= lane_fired[l];
    end
  end

  assign fired_o = fired_q;

  p_fired_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fired_o));

  p_no_carry_fired_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc |-> ((lane_carry & lane_fired) == '0));
endmodule

// File: tb/nrn_step_unit_tb_top.sv
`timescale 1ns/1ps
module nrn_step_unit_tb_top;
  localparam int N  = 20;
  localparam int CW = 8;
  localparam int T  = 4;
  localparam int G  = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    leak_mode = 2'd1;
  logic signed [CW-1:0] min_pot = '0;
  logic [N*CW-1:0] thr_bus = '0;
  logic [N-1:0]  leak_mask = '0;
  logic          dep_valid = 1'b0;
  logic [4:0]    dep_col = '0;
  logic [1:0]    dep_delay = '0;
  logic signed [CW-1:0] dep_val = '0;
  logic          busy, done;
  logic [N-1:0]  fired;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nrn_step_unit #(.N_NEURONS(N), .LANES(8), .T_STEPS(T), .CW(CW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .leak_mode_i (leak_mode),
    .min_pot_i   (min_pot),
    .thr_i       (thr_bus),
    .leak_mask_i (leak_mask),
    .dep_valid_i (dep_valid),
    .dep_col_i   (dep_col),
    .dep_delay_i (dep_delay),
    .dep_val_i   (dep_val),
    .busy_o      (busy),
    .done_o      (done),
    .fired_o     (fired)
  );

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_mask(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic set_thr_all(input int v);
    for (int i = 0; i < N; i++) thr_bus[i*CW +: CW] = CW'(v);
  endtask

  task automatic set_thr(input int n, input int v);
    thr_bus[n*CW +: CW] = CW'(v);
  endtask

  task automatic deposit(input int col, input int dly, input int val);
    @(negedge clk);
    dep_valid = 1'b1;
    dep_col   = 5'(col);
    dep_delay = 2'(dly);
    dep_val   = CW'(val);
    @(negedge clk);
    dep_valid = 1'b0;
  endtask

  // one timestep; optional check of the fired mask; inj pokes start and a deposit mid-step
  task automatic do_step(input string req, input bit use_exp, input logic [N-1:0] exp, input bit inj);
    int cnt;
    logic [N-1:0] m;
    cnt = 0;
    @(negedge clk);
    start = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      dep_valid = 1'b0;
      if (inj && cnt == 1) begin
        start = 1'b1;
        dep_valid = 1'b1;
        dep_col = 5'd11;
        dep_delay = 2'd1;
        dep_val = 8'sd50;
      end
    end while (!done && cnt < 40);
    check_int("R11 done latency", cnt, G + 1);
    m = fired;
    if (use_exp) check_mask(req, m, exp);
    @(negedge clk);
    check_int("R11 done single pulse", int'(done), 0);
    check_int("R11 idle after done", int'(busy), 0);
    check_mask("R11 fired hold", fired, m);
  endtask

  task automatic flush();
    leak_mode = 2'd1;
    min_pot = '0;
    set_thr_all(100);
    leak_mask = '0;
    for (int i = 0; i < T; i++) do_step("flush", 1'b0, '0, 1'b0);
  endtask

  task automatic t_reset();
    check_mask("R1 fired at reset", fired, '0);
    check_int("R1 done at reset", int'(done), 0);
    check_int("R1 busy at reset", int'(busy), 0);
    set_thr_all(0);
    leak_mode = 2'd1;
    min_pot = -8'sd1;
    do_step("R1 buffer zero at reset", 1'b1, {N{1'b1}}, 1'b0);
  endtask

  task automatic t_inclusive();
    flush();
    set_thr_all(5);
    deposit(0, 0, 5);
    deposit(1, 0, 4);
    deposit(8, 0, 6);
    deposit(16, 0, 4);
    deposit(19, 0, 5);
    do_step("R3 R9 inclusive fire incl last group", 1'b1, 20'h80101, 1'b0);
  endtask

  task automatic t_thr_zero();
    flush();
    set_thr(2, 0);
    set_thr(6, 0);
    deposit(6, 0, -6);
    do_step("R2 R4 clamp to zero then fire", 1'b1, 20'h00044, 1'b0);
    min_pot = -8'sd4;
    deposit(6, 0, -6);
    do_step("R4 negative clamped charge no fire", 1'b1, 20'h00004, 1'b0);
    min_pot = '0;
  endtask

  task automatic t_carry();
    flush();
    leak_mode = 2'd0;
    set_thr_all(10);
    deposit(1, 0, 6);
    deposit(2, 0, 12);
    do_step("R5 first step", 1'b1, 20'h00004, 1'b0);
    deposit(1, 0, 4);
    deposit(2, 0, 5);
    do_step("R5 R7 carry adds, fired not carried", 1'b1, 20'h00002, 1'b0);
  endtask

  task automatic t_leak();
    flush();
    leak_mode = 2'd2;
    set_thr_all(10);
    leak_mask = '0;
    leak_mask[3] = 1'b1;
    deposit(3, 0, 7);
    deposit(4, 0, 7);
    do_step("R6 cfg first step", 1'b1, '0, 1'b0);
    deposit(3, 0, 3);
    deposit(4, 0, 3);
    do_step("R6 cfg per-neuron leak", 1'b1, 20'h00010, 1'b0);
    flush();
    leak_mode = 2'd1;
    set_thr_all(10);
    deposit(5, 0, 7);
    do_step("R6 all first step", 1'b1, '0, 1'b0);
    deposit(5, 0, 3);
    do_step("R6 all leaks everything", 1'b1, '0, 1'b0);
  endtask

  task automatic t_sat();
    flush();
    leak_mode = 2'd0;
    set_thr_all(127);
    deposit(7, 0, 100);
    deposit(7, 0, 100);
    deposit(8, 0, 100);
    do_step("R10 deposit saturates", 1'b1, 20'h00080, 1'b0);
    deposit(8, 0, 100);
    do_step("R10 carry saturates", 1'b1, 20'h00100, 1'b0);
  endtask

  task automatic t_delay();
    flush();
    set_thr_all(100);
    set_thr(9, 1);
    deposit(9, 2, 1);
    do_step("R13 delay 2 step 1", 1'b1, '0, 1'b0);
    do_step("R13 delay 2 step 2", 1'b1, '0, 1'b0);
    do_step("R13 delay 2 arrives", 1'b1, 20'h00200, 1'b0);
  endtask

  task automatic t_wipe();
    flush();
    leak_mode = 2'd0;
    set_thr_all(100);
    set_thr(10, 5);
    deposit(10, 0, 3);
    for (int i = 0; i <= T; i++) do_step("R8 no stale charge after wrap", 1'b1, '0, 1'b0);
  endtask

  task automatic t_busy();
    flush();
    set_thr_all(100);
    set_thr(11, 1);
    do_step("R12 R11 step with mid-step start and deposit", 1'b1, '0, 1'b1);
    do_step("R12 busy deposit dropped a", 1'b1, '0, 1'b0);
    do_step("R12 busy deposit dropped b", 1'b1, '0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_inclusive();
    t_thr_zero();
    t_carry();
    t_leak();
    t_sat();
    t_delay();
    t_wipe();
    t_busy();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule